// File: doc/BRIEF.md
# Duplex Grid/Segment Dimming Sequencer

This block drives a two-grid multiplexed fluorescent display. A frame is made of bit times, and each bit time lasts a fixed number of oscillator clocks. The frame splits into two equal halves. The first half strobes the first grid and the second half strobes the second grid. During each half, the 30 segment outputs carry the display bits that belong to the active grid. The segments are blanked outside an on-window whose length follows the current brightness setting.

Brightness is one on-time per half, counted in bit times. A night input chooses between two cases:
- Day operation uses the full on-time.
- Night operation uses a dimming value. A mode input picks this value from one of two sources:
  - an 11-bit digital duty value, capped so that a guard gap always remains between the two grids;
  - a count that an external analog comparator produces, capped at one eighth of a half.

The on-time in use is taken at the last clock of a frame, so a frame never shows a mix of two settings. An active-low test input lights every segment and turns both grids on, whatever else the block is doing.

Top module: `dseq_duplex_dimmer`

## Requirements
- R1: A bit time is 4 clocks and a frame is 4096 bit times, counted from 0 at reset release. Frame positions 0-2047 belong to grid 1 (`grid_n[0]`) and positions 2048-4095 belong to grid 2 (`grid_n[1]`). Never are both grids on at once.
- R2: Let p be the position within the current half and T the on-time in use. The grid of the current half is on (its output low) while p < T, and off (high) otherwise. The other grid stays off.
- R3: The segment window is open while T > 0 and p < T + 6. Segments are 0 outside this window. With T = 2032, this leaves segments on for 6 bit times after the grid goes off and blanked for the last 10 bit times of the half.
- R4: Inside the window, `seg[n]` equals `disp_latch[n]` during the grid 1 half and `disp_latch[n+30]` during the grid 2 half. A high output is a lit segment.
- R5: With `night` = 0, T = 2032 regardless of the mode and the dimming inputs.
- R6: With `night` = 1 and `dig_mode` = 1, T = min(`duty_dig`, 2032).
- R7: With `night` = 1 and `dig_mode` = 0, T = min(`ana_count`, 256).
- R8: The block samples T from the inputs at the last clock of each frame and holds it for the whole next frame. Changes to `night`, `dig_mode`, `duty_dig` or `ana_count` during a frame have no effect on that frame. T is 0 in the first frame after reset.
- R9: While `test_n` is low, every segment output is 1 and both grid outputs are 0, starting in the same cycle.
- R10: During reset, with `test_n` high, both grid outputs are 1 and all segments are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_latch | input | 60 | Display bits: [29:0] for grid 1, [59:30] for grid 2 |
| duty_dig | input | 11 | Digital duty value in 1/2048 steps |
| ana_count | input | 9 | On-time count from the analog comparator |
| dig_mode | input | 1 | 1 selects digital dimming, 0 selects analog |
| night | input | 1 | 1 selects dimmed operation, 0 selects full brightness |
| test_n | input | 1 | Active-low lamp test |
| grid_n | output | 2 | Active-low grid strobes, bit 0 = grid 1 |
| seg | output | 30 | Segment outputs, active high |

## Verification
The hardest behaviour to bring about from the ports is the frame-deferred update. The on-time register changes only once per 16384 clocks, so stale or premature values show up only when a setting changes in the middle of a frame and the edges are then observed in both that frame and the next. The stimulus therefore reprograms every dimming input at the midpoint of each frame. It samples the second half against the old on-time and the following frame against the new one. The samples fall on the last clock of bit time T-1 and the first clock of bit times T and T+6, and the frames cover the clamp limits 2031/2033 and 300, zero duty, and random settings.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic {
    SRC_ANALOG  = 1'b0,
    SRC_DIGITAL = 1'b1
  } dim_src_e;

  // Saturating limit used for both dimming sources.
  function automatic int unsigned cap_value(int unsigned v, int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

  // Grid strobe of the active half is on for the first 'on' bit times.
  function automatic logic grid_window(int unsigned p, int unsigned on);
    return p < on;
  endfunction

  // Segment window trails the grid by 'ext' bit times; closed when dark.
  function automatic logic seg_window(int unsigned p, int unsigned on, int unsigned ext);
    return (on != 0) && (p < on + ext);
  endfunction

endpackage

// File: rtl/dseq_timebase.sv
module dseq_timebase #(
  parameter int CLK_PER_BIT = 4,
  parameter int FRAME_BITS  = 4096,
  localparam int PRE_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos,
  output logic             bit_tick,
  output logic             frame_end
);

  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_BIT - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);

  logic [PRE_W-1:0] pre;

  assign bit_tick  = (pre == PRE_LAST);
  assign frame_end = bit_tick && (pos == POS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      pos <= '0;
    end else begin
      pre <= bit_tick ? '0 : pre + 1'b1;
      if (bit_tick) begin
        pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dseq_duty_sel.sv
module dseq_duty_sel
  import dseq_pkg::*;
#(
  parameter int DUTY_W  = 11,
  parameter int ANA_W   = 9,
  parameter int ON_W    = 11,
  parameter int DAY_ON  = 2032,
  parameter int DIG_MAX = 2032,
  parameter int ANA_MAX = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              night,
  input  logic              dig_mode,
  input  logic [DUTY_W-1:0] duty_dig,
  input  logic [ANA_W-1:0]  ana_count,
  output logic [ON_W-1:0]   on_next,
  output logic [ON_W-1:0]   on_q
);

  dim_src_e    src;
  int unsigned dig_on;
  int unsigned ana_on;
  int unsigned pick;

  assign src = dim_src_e'(dig_mode);

  always_comb begin
    dig_on = cap_value(32'(duty_dig), DIG_MAX);
    ana_on = cap_value(32'(ana_count), ANA_MAX);
    if (!night) begin
      pick = DAY_ON;
    end else if (src == SRC_DIGITAL) begin
      pick = dig_on;
    end else begin
      pick = ana_on;
    end
    on_next = ON_W'(pick);
  end

  // Held for a whole frame so both halves share one on-time.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q <= '0;
    end else if (frame_end) begin
      on_q <= on_next;
    end
  end

endmodule

// File: rtl/dseq_out_gate.sv
module dseq_out_gate
  import dseq_pkg::*;
#(
  parameter int FRAME_BITS = 4096,
  parameter int NSEG       = 30,
  parameter int NGRID      = 2,
  parameter int SEG_EXT    = 6,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int ON_W  = POS_W - 1
) (
  input  logic [POS_W-1:0]       pos,
  input  logic [ON_W-1:0]        on_q,
  input  logic [NGRID*NSEG-1:0]  disp_latch,
  input  logic                   test_n,
  output logic [NGRID-1:0]       grid_n,
  output logic [NSEG-1:0]        seg
);

  logic [ON_W-1:0] p;
  logic            half;
  logic            grid_on;
  logic            seg_on;

  assign p       = pos[ON_W-1:0];
  assign half    = pos[POS_W-1];
  assign grid_on = grid_window(32'(p), 32'(on_q));
  assign seg_on  = seg_window(32'(p), 32'(on_q), SEG_EXT);

  for (genvar g = 0; g < NGRID; g++) begin : g_grid
    assign grid_n[g] = test_n & ~(grid_on & (half == 1'(g)));
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic data_bit;
    assign data_bit = half ? disp_latch[i + NSEG] : disp_latch[i];
    assign seg[i]   = ~test_n | (seg_on & data_bit);
  end

endmodule

// File: rtl/dseq_duplex_dimmer.sv
module dseq_duplex_dimmer #(
  parameter int CLK_PER_BIT = 4,
  parameter int FRAME_BITS  = 4096,
  parameter int NSEG        = 30,
  parameter int DUTY_W      = 11,
  parameter int ANA_W       = 9,
  parameter int DAY_ON      = 2032,
  parameter int DIG_MAX     = 2032,
  parameter int ANA_MAX     = 256,
  parameter int SEG_EXT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NSEG-1:0] disp_latch,
  input  logic [DUTY_W-1:0] duty_dig,
  input  logic [ANA_W-1:0]  ana_count,
  input  logic              dig_mode,
  input  logic              night,
  input  logic              test_n,
  output logic [1:0]        grid_n,
  output logic [NSEG-1:0]   seg
);

  localparam int POS_W = $clog2(FRAME_BITS);
  localparam int ON_W  = POS_W - 1;

  logic [POS_W-1:0] pos;
  logic             bit_tick;
  logic             frame_end;
  logic [ON_W-1:0]  on_next;
  logic [ON_W-1:0]  on_q;

  dseq_timebase #(
    .CLK_PER_BIT(CLK_PER_BIT),
    .FRAME_BITS (FRAME_BITS)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos      (pos),
    .bit_tick (bit_tick),
    .frame_end(frame_end)
  );

  dseq_duty_sel #(
    .DUTY_W (DUTY_W),
    .ANA_W  (ANA_W),
    .ON_W   (ON_W),
    .DAY_ON (DAY_ON),
    .DIG_MAX(DIG_MAX),
    .ANA_MAX(ANA_MAX)
  ) u_duty (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_end(frame_end),
    .night    (night),
    .dig_mode (dig_mode),
    .duty_dig (duty_dig),
    .ana_count(ana_count),
    .on_next  (on_next),
    .on_q     (on_q)
  );

  dseq_out_gate #(
    .FRAME_BITS(FRAME_BITS),
    .NSEG      (NSEG),
    .NGRID     (2),
    .SEG_EXT   (SEG_EXT)
  ) u_gate (
    .pos       (pos),
    .on_q      (on_q),
    .disp_latch(disp_latch),
    .test_n    (test_n),
    .grid_n    (grid_n),
    .seg       (seg)
  );

endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
  parameter int CLK_PER_BIT = 4,
  parameter int FRAME_BITS  = 4096,
  parameter int NSEG        = 30,
  parameter int DAY_ON      = 2032,
  parameter int DIG_MAX     = 2032,
  parameter int SEG_EXT     = 6,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int ON_W  = POS_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_n,
  input logic [POS_W-1:0]  pos,
  input logic              bit_tick,
  input logic              frame_end,
  input logic [ON_W-1:0]   on_q,
  input logic [1:0]        grid_n,
  input logic [NSEG-1:0]   seg,
  input logic [2*NSEG-1:0] disp_latch
);

  localparam int CAP        = (DAY_ON > DIG_MAX) ? DAY_ON : DIG_MAX;
  localparam int BLANK_FROM = CAP + SEG_EXT;

  assert_one_grid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    test_n |-> $onehot0(~grid_n));

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  assert_grid_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_n && $fell(grid_n[0])) |-> (pos == '0));

  assert_seg_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_n && (32'(pos[ON_W-1:0]) >= BLANK_FROM)) |-> (seg == '0));

  assert_seg_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_n && !grid_n[1]) |-> (seg == disp_latch[2*NSEG-1:NSEG]));

  assert_on_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(on_q) <= CAP);

  assert_frame_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(on_q));

  assert_lamp_test_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !test_n |-> ((&seg) && (grid_n == 2'b00)));

endmodule

bind dseq_duplex_dimmer dseq_checker #(
  .CLK_PER_BIT(CLK_PER_BIT),
  .FRAME_BITS (FRAME_BITS),
  .NSEG       (NSEG),
  .DAY_ON     (DAY_ON),
  .DIG_MAX    (DIG_MAX),
  .SEG_EXT    (SEG_EXT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_n    (test_n),
  .pos       (pos),
  .bit_tick  (bit_tick),
  .frame_end (frame_end),
  .on_q      (on_q),
  .grid_n    (grid_n),
  .seg       (seg),
  .disp_latch(disp_latch)
);

// File: tb/tb_dseq_duplex_dimmer.sv
module tb_dseq_duplex_dimmer;

  localparam int CPB      = 4;
  localparam int FRAME    = 4096;
  localparam int HALF     = 2048;
  localparam int FCLK     = CPB * FRAME;
  localparam int N_FRAMES = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [59:0] disp_latch = '0;
  logic [10:0] duty_dig = '0;
  logic [8:0]  ana_count = '0;
  logic        dig_mode = 1'b0;
  logic        night = 1'b0;
  logic        test_n = 1'b1;
  logic [1:0]  grid_n;
  logic [29:0] seg;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int on_cur = 0;
  int on_nxt = 0;
  string tag_cur = "R8";
  string tag_nxt = "R8";

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  dseq_duplex_dimmer dut (
    .clk(clk), .rst_n(rst_n), .disp_latch(disp_latch), .duty_dig(duty_dig),
    .ana_count(ana_count), .dig_mode(dig_mode), .night(night), .test_n(test_n),
    .grid_n(grid_n), .seg(seg)
  );

  function automatic int exp_on(bit nt, bit dg, int d, int a);
    if (!nt) return 2032;
    if (dg) return (d > 2032) ? 2032 : d;
    return (a > 256) ? 256 : a;
  endfunction

  task automatic check2(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // Sample frame fr, position pa (0..4095), clock sub (0..3) within the bit time.
  task automatic check_at(int fr, int pa, int sub);
    int target;
    int h;
    int p;
    logic [1:0]  eg;
    logic [29:0] es;
    if (pa < 0) return;
    target = fr * FCLK + pa * CPB + sub;
    if (target < cyc) return;
    while (cyc < target) @(negedge clk);
    h  = pa / HALF;
    p  = pa % HALF;
    eg = 2'b11;
    if (p < on_cur) eg[h] = 1'b0;
    es = '0;
    if (on_cur != 0 && p < on_cur + 6) es = h ? disp_latch[59:30] : disp_latch[29:0];
    check2({"R1 R2 grid ", tag_cur}, 32'(grid_n), 32'(eg));
    check2({"R3 R4 seg ", tag_cur}, 32'(seg), 32'(es));
  endtask

  task automatic check_half(int fr, int h);
    int b;
    b = h * HALF;
    check_at(fr, b, 0);
    check_at(fr, b + on_cur - 1, 3);
    check_at(fr, b + on_cur, 0);
    check_at(fr, b + on_cur + 5, 3);
    check_at(fr, b + on_cur + 6, 0);
    check_at(fr, b + HALF - 1, 3);
  endtask

  task automatic set_inputs(int k);
    disp_latch = {$urandom, $urandom};
    night    = 1'b1;
    dig_mode = 1'b1;
    duty_dig = 11'($urandom);
    ana_count = 9'($urandom);
    case (k)
      1: begin night = 1'b0; dig_mode = 1'($urandom); tag_nxt = "R5 day"; end
      2: begin duty_dig = 11'd2033; tag_nxt = "R6 cap 2033"; end
      3: begin duty_dig = 11'd2031; tag_nxt = "R6 2031"; end
      4: begin duty_dig = 11'd0; tag_nxt = "R6 zero dark"; end
      5: begin dig_mode = 1'b0; ana_count = 9'd300; tag_nxt = "R7 cap 300"; end
      6: begin dig_mode = 1'b0; ana_count = 9'd100; tag_nxt = "R7 100"; end
      7: begin tag_nxt = "R6 random"; end
      default: begin dig_mode = 1'b0; tag_nxt = "R7 random"; end
    endcase
    on_nxt = exp_on(night, dig_mode, int'(duty_dig), int'(ana_count));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0D15));
    disp_latch = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    check2("R10 reset grid", 32'(grid_n), 32'(2'b11));
    check2("R10 reset seg", 32'(seg), 32'(0));
    rst_n = 1'b1;
    for (int fr = 0; fr < N_FRAMES; fr++) begin
      on_cur  = (fr == 0) ? 0 : on_nxt;
      tag_cur = (fr == 0) ? "R8 first frame" : tag_nxt;
      check_at(fr, 0, 2);
      if (fr == 1) begin
        check_at(fr, 100, 1);
        test_n = 1'b0;
        #1;
        check2("R9 test seg", 32'(seg), 32'h3FFF_FFFF);
        check2("R9 test grid", 32'(grid_n), 32'(2'b00));
        @(negedge clk);
        test_n = 1'b1;
      end
      check_half(fr, 0);
      set_inputs(fr + 1);
      tag_cur = {tag_cur, " R8 mid-frame change"};
      check_half(fr, 1);
    end
    summary();
    $finish;
  end

endmodule